// File: doc/BRIEF.md
# Float-to-int8 saturating requantizer

This block takes a stream of single-precision floating-point values that have already been scaled. It turns each one into a signed 8-bit integer. Every accepted element is first rounded to a 32-bit integer, and the rounding direction is selectable. The result is then saturated by the clamp chosen in the configuration, and the low byte is kept. Inputs too large for the integer range saturate before the clamp. A not-a-number input becomes zero.

The resulting bytes are collected into a wide output word, four lanes by default. The first accepted element lands in the lowest byte. A word is emitted after every fourth accepted element. A flush input closes a partially filled word early and zeroes the lanes it did not fill.

The configuration inputs are meant to be held steady while a word is being built. A bias add and a scale multiply are expected upstream of this block.

Top module: `f2i8_requant`

## Requirements
- R1: During and after reset, with no input yet accepted, `out_valid` is 0 and `out_data` is 0.
- R2: With `cfg_round` = 0 (nearest), a value rounds to the nearest integer, and an exact half goes to the even neighbour (2.5 gives 2, 3.5 gives 4, -2.5 gives -2, 0.5 gives 0).
- R3: With `cfg_round` = 1 (toward zero), the fraction is dropped (2.7 gives 2, -3.7 gives -3).
- R4: A NaN input (exponent all ones, mantissa non-zero) yields 0. An infinity, or a finite value whose magnitude exceeds the 32-bit signed range, saturates to that range before the clamp.
- R5: With `cfg_mode` = 0 or 3 (symmetric), the result is limited to [-B, +B], where B is `cfg_bound` read as unsigned and capped at 127.
- R6: With `cfg_mode` = 1 (two-limit), the result is max(min(x, `cfg_hi`), `cfg_lo`), with both limits signed 8-bit. When lo > hi, every result equals lo.
- R7: With `cfg_mode` = 2 (rectifier), negative results become 0 and results above 127 become 127.
- R8: The k-th accepted element of a word occupies bits 8k+7:8k. Lane 0 is bits 7:0, and bytes are two's complement. `out_valid` rises for one cycle, in the cycle after the clock edge that accepts the fourth element.
- R9: When `flush` is high with at least one element held, the held lanes are emitted in the next cycle, and the unfilled lanes read 0. A flush with nothing held produces no output.
- R10: `out_valid` stays low unless an element or a flush was accepted on the previous edge. In particular, it stays low after one to three accepted elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept `in_data` on this edge |
| in_data | input | 32 | Single-precision input value |
| flush | input | 1 | Emit a partially filled word |
| cfg_mode | input | 2 | 0/3 symmetric, 1 two-limit, 2 rectifier |
| cfg_round | input | 1 | 0 nearest-even, 1 toward zero |
| cfg_bound | input | 8 | Symmetric bound, capped at 127 |
| cfg_lo | input | 8 | Signed lower limit, two-limit mode |
| cfg_hi | input | 8 | Signed upper limit, two-limit mode |
| out_valid | output | 1 | Packed word valid for one cycle |
| out_data | output | 32 | Packed signed bytes, lane 0 in bits 7:0 |

## Verification
The bench builds two copies of the block with the default four lanes and a 32-bit integer stage. One copy uses the minimum/maximum form of the symmetric clamp and the other the direct compare form. Both are fed the same stimulus and checked against the same expected words, so any disagreement between the two clamp structures is reported. The four-lane default puts word completion, partial flush and per-lane byte placement within reach of short directed sequences. The 32-bit integer stage brings the overflow saturation of infinities and values near 3e9 into play.

// File: rtl/rq_pkg.sv
package rq_pkg;
    typedef enum logic [1:0] {
        CLAMP_SYM     = 2'd0,
        CLAMP_TWO     = 2'd1,
        CLAMP_RELU    = 2'd2,
        CLAMP_SYM_ALT = 2'd3
    } clamp_mode_e;

    localparam int FP_W    = 32;
    localparam int FP_EXP  = 8;
    localparam int FP_MAN  = 23;
    localparam int FP_BIAS = 127;
endpackage

// File: rtl/rq_round.sv
module rq_round #(
    parameter int INT_W = 32
) (
    input  logic [rq_pkg::FP_W-1:0] in_f,
    input  logic                    trunc_mode,
    output logic signed [INT_W-1:0] out_i
);
    import rq_pkg::*;

    localparam int FRAC_W = 32;
    localparam int FX_W   = INT_W + FRAC_W;
    localparam logic signed [INT_W-1:0] I_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic signed [INT_W-1:0] I_MIN = {1'b1, {(INT_W-1){1'b0}}};

    logic              sgn;
    logic [FP_EXP-1:0] ex;
    logic [FP_MAN-1:0] man;
    logic              is_nan;
    logic              is_zero;
    logic              is_sat;
    int                unb;
    logic [FX_W-1:0]   fx;
    logic [INT_W-1:0]  ip;
    logic [FRAC_W-1:0] frac;
    logic              up;
    logic [INT_W:0]    mag;

    always_comb begin
        sgn     = in_f[FP_W-1];
        ex      = in_f[FP_W-2:FP_MAN];
        man     = in_f[FP_MAN-1:0];
        is_nan  = (ex == '1) && (man != '0);
        unb     = int'(ex) - FP_BIAS;
        is_zero = 1'b0;
        is_sat  = 1'b0;
        fx      = '0;
        if (is_nan || ex == '0) begin
            is_zero = 1'b1;
        end else if (ex == '1 || unb >= INT_W - 1) begin
            is_sat = 1'b1;
        end else if (unb < -1) begin
            is_zero = 1'b1;
        end else begin
            fx = {{(FX_W-FP_MAN-1){1'b0}}, 1'b1, man} << (unb + FRAC_W - FP_MAN);
        end
        ip   = fx[FX_W-1:FRAC_W];
        frac = fx[FRAC_W-1:0];
        up   = !trunc_mode && frac[FRAC_W-1] && ((|frac[FRAC_W-2:0]) || ip[0]);
        mag  = {1'b0, ip} + {{INT_W{1'b0}}, up};

        if (is_zero) begin
            out_i = '0;
        end else if (is_sat) begin
            out_i = sgn ? I_MIN : I_MAX;
        end else if (!sgn && mag[INT_W-1]) begin
            out_i = I_MAX;
        end else if (sgn) begin
            out_i = -$signed(mag[INT_W-1:0]);
        end else begin
            out_i = $signed(mag[INT_W-1:0]);
        end
    end

    // R4: a NaN pattern on the input never leaves a non-zero integer
    always_comb begin
        if (in_f[FP_W-2:FP_MAN] == '1 && in_f[FP_MAN-1:0] != '0)
            p_nan_zero_r4: assert (out_i == '0);
    end
endmodule

// File: rtl/rq_clamp.sv
module rq_clamp #(
    parameter int INT_W      = 32,
    parameter int OUT_W      = 8,
    parameter bit SYM_MINMAX = 1'b0
) (
    input  logic signed [INT_W-1:0] in_v,
    input  logic [1:0]              mode,
    input  logic [OUT_W-1:0]        bound,
    input  logic [OUT_W-1:0]        lo,
    input  logic [OUT_W-1:0]        hi,
    output logic [OUT_W-1:0]        out_b
);
    import rq_pkg::*;

    localparam logic signed [INT_W-1:0] QMAX = INT_W'((1 << (OUT_W - 1)) - 1);

    logic signed [INT_W-1:0] b_raw;
    logic signed [INT_W-1:0] b_pos;
    logic signed [INT_W-1:0] b_neg;
    logic signed [INT_W-1:0] lo_x;
    logic signed [INT_W-1:0] hi_x;
    logic signed [INT_W-1:0] sym_v;
    logic signed [INT_W-1:0] two_v;
    logic signed [INT_W-1:0] two_t;
    logic signed [INT_W-1:0] relu_v;
    logic signed [INT_W-1:0] res;

    always_comb begin
        b_raw = $signed({{(INT_W-OUT_W){1'b0}}, bound});
        b_pos = (b_raw > QMAX) ? QMAX : b_raw;
        b_neg = -b_pos;
        lo_x  = $signed({{(INT_W-OUT_W){lo[OUT_W-1]}}, lo});
        hi_x  = $signed({{(INT_W-OUT_W){hi[OUT_W-1]}}, hi});
    end

    generate
        if (SYM_MINMAX) begin : g_sym_minmax
            logic signed [INT_W-1:0] min_t;
            always_comb begin
                min_t = (in_v < b_pos) ? in_v : b_pos;
                sym_v = (min_t > b_neg) ? min_t : b_neg;
            end
        end else begin : g_sym_direct
            always_comb begin
                if (in_v > b_pos)      sym_v = b_pos;
                else if (in_v < b_neg) sym_v = b_neg;
                else                   sym_v = in_v;
            end
        end
    endgenerate

    always_comb begin
        two_t  = (in_v < hi_x) ? in_v : hi_x;
        two_v  = (two_t > lo_x) ? two_t : lo_x;
        if (in_v < 0)         relu_v = '0;
        else if (in_v > QMAX) relu_v = QMAX;
        else                  relu_v = in_v;
        case (clamp_mode_e'(mode))
            CLAMP_TWO:  res = two_v;
            CLAMP_RELU: res = relu_v;
            default:    res = sym_v;
        endcase
        out_b = res[OUT_W-1:0];
    end

    // R7: rectifier output is never negative
    always_comb begin
        if (clamp_mode_e'(mode) == CLAMP_RELU)
            p_relu_floor_r7: assert (!out_b[OUT_W-1]);
    end

    // R5: symmetric output magnitude never exceeds the capped bound
    always_comb begin
        if (mode == 2'd0 || mode == 2'd3)
            p_sym_range_r5: assert ($signed(out_b) <= $signed(b_pos[OUT_W-1:0])
                                    && $signed(out_b) >= -$signed(b_pos[OUT_W-1:0]));
    end
endmodule

// File: rtl/rq_pack.sv
module rq_pack #(
    parameter int LANES = 4,
    parameter int OUT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [OUT_W-1:0]       in_byte,
    input  logic                   flush,
    output logic                   out_valid,
    output logic [LANES*OUT_W-1:0] out_word
);
    localparam int WORD_W = LANES * OUT_W;
    localparam int CNT_W  = $clog2(LANES + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] fill;
        logic              ovld;
        logic [WORD_W-1:0] oword;
    } pack_st_t;

    pack_st_t st_d, st_q;
    logic [WORD_W-1:0] fill_x;
    logic [CNT_W-1:0]  cnt_x;
    logic              full_x;

    always_comb begin
        st_d      = st_q;
        st_d.ovld = 1'b0;
        fill_x    = st_q.fill;
        cnt_x     = st_q.cnt;
        if (in_valid) begin
            fill_x[st_q.cnt*OUT_W +: OUT_W] = in_byte;
            cnt_x = st_q.cnt + CNT_W'(1);
        end
        full_x = (cnt_x == CNT_W'(LANES));
        if (full_x || (flush && cnt_x != '0)) begin
            st_d.ovld  = 1'b1;
            st_d.oword = fill_x;
            st_d.fill  = '0;
            st_d.cnt   = '0;
        end else begin
            st_d.fill = fill_x;
            st_d.cnt  = cnt_x;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ovld;
    assign out_word  = st_q.oword;

    p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(LANES));

    p_out_has_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid || flush));

    p_empty_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !in_valid && st_q.cnt == '0) |=> !out_valid);
endmodule

// File: rtl/f2i8_requant.sv
module f2i8_requant #(
    parameter int LANES      = 4,
    parameter int OUT_W      = 8,
    parameter int INT_W      = 32,
    parameter bit SYM_MINMAX = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [31:0]            in_data,
    input  logic                   flush,
    input  logic [1:0]             cfg_mode,
    input  logic                   cfg_round,
    input  logic [OUT_W-1:0]       cfg_bound,
    input  logic [OUT_W-1:0]       cfg_lo,
    input  logic [OUT_W-1:0]       cfg_hi,
    output logic                   out_valid,
    output logic [LANES*OUT_W-1:0] out_data
);
    logic signed [INT_W-1:0] int_v;
    logic [OUT_W-1:0]        byte_v;

    rq_round #(.INT_W(INT_W)) u_round (
        .in_f       (in_data),
        .trunc_mode (cfg_round),
        .out_i      (int_v)
    );

    rq_clamp #(.INT_W(INT_W), .OUT_W(OUT_W), .SYM_MINMAX(SYM_MINMAX)) u_clamp (
        .in_v  (int_v),
        .mode  (cfg_mode),
        .bound (cfg_bound),
        .lo    (cfg_lo),
        .hi    (cfg_hi),
        .out_b (byte_v)
    );

    rq_pack #(.LANES(LANES), .OUT_W(OUT_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (byte_v),
        .flush     (flush),
        .out_valid (out_valid),
        .out_word  (out_data)
    );

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/f2i8_requant_tb_top.sv
module f2i8_requant_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        flush = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_round = 1'b0;
    logic [7:0]  cfg_bound = 8'd127;
    logic [7:0]  cfg_lo = 8'd0;
    logic [7:0]  cfg_hi = 8'd0;
    logic        ov_i, ov_n;
    logic [31:0] od_i, od_n;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    f2i8_requant #(.SYM_MINMAX(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .flush(flush), .cfg_mode(cfg_mode), .cfg_round(cfg_round),
        .cfg_bound(cfg_bound), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .out_valid(ov_i), .out_data(od_i));

    f2i8_requant #(.SYM_MINMAX(1'b0)) dut_n (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .flush(flush), .cfg_mode(cfg_mode), .cfg_round(cfg_round),
        .cfg_bound(cfg_bound), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .out_valid(ov_n), .out_data(od_n));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic expect_word(input string req, input logic [31:0] exp);
        chk({req, " valid"}, {31'd0, ov_i}, 32'd1);
        chk({req, " word"}, od_i, exp);
        chk({req, " valid alt-clamp"}, {31'd0, ov_n}, 32'd1);
        chk({req, " word alt-clamp"}, od_n, exp);
    endtask

    task automatic expect_idle(input string req);
        chk({req, " idle"}, {31'd0, ov_i}, 32'd0);
        chk({req, " idle alt-clamp"}, {31'd0, ov_n}, 32'd0);
    endtask

    task automatic setup(input logic [1:0] m, input logic r, input logic [7:0] b,
                         input logic [7:0] l, input logic [7:0] h);
        cfg_mode = m; cfg_round = r; cfg_bound = b; cfg_lo = l; cfg_hi = h;
    endtask

    task automatic push(input logic [31:0] x);
        in_valid = 1'b1; in_data = x;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic push4(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input logic [31:0] d);
        push(a); push(b); push(c); push(d);
    endtask

    task automatic t_reset;
        expect_idle("R1 reset");
        chk("R1 reset data", od_i, 32'd0);
    endtask

    task automatic t_nearest;
        setup(2'd0, 1'b0, 8'd127, 8'd0, 8'd0);
        push4(32'h40200000, 32'h40600000, 32'hC0200000, 32'h3F000000);
        expect_word("R2 ties-to-even", 32'h00FE0402);
    endtask

    task automatic t_trunc;
        setup(2'd0, 1'b1, 8'd127, 8'd0, 8'd0);
        push4(32'h402CCCCD, 32'hC02CCCCD, 32'h3FC00000, 32'hC06CCCCD);
        expect_word("R3 toward-zero", 32'hFD01FE02);
    endtask

    task automatic t_special;
        setup(2'd0, 1'b0, 8'd127, 8'd0, 8'd0);
        push4(32'h7FC00000, 32'h7F800000, 32'h4F32D05E, 32'hFF800000);
        expect_word("R4 nan/inf/overflow", 32'h817F7F00);
    endtask

    task automatic t_sym;
        setup(2'd0, 1'b0, 8'd5, 8'd0, 8'd0);
        push4(32'h41200000, 32'hC1200000, 32'h40400000, 32'hC3480000);
        expect_word("R5 bound 5", 32'hFB03FB05);
        setup(2'd3, 1'b0, 8'd255, 8'd0, 8'd0);
        push4(32'h43480000, 32'hC3480000, 32'h3F800000, 32'h00000000);
        expect_word("R5 bound capped 127", 32'h0001817F);
    endtask

    task automatic t_two;
        setup(2'd1, 1'b0, 8'd0, 8'hFD, 8'd100);
        push4(32'hC1200000, 32'h43480000, 32'h40A00000, 32'hBF800000);
        expect_word("R6 lo=-3 hi=100", 32'hFF0564FD);
        setup(2'd1, 1'b0, 8'd0, 8'd10, 8'd2);
        push4(32'h00000000, 32'h42C80000, 32'hC0A00000, 32'h40A00000);
        expect_word("R6 lo above hi", 32'h0A0A0A0A);
    endtask

    task automatic t_relu;
        setup(2'd2, 1'b0, 8'd0, 8'd0, 8'd0);
        push4(32'hC0A00000, 32'h40A00000, 32'h43480000, 32'hC3480000);
        expect_word("R7 rectifier", 32'h007F0500);
    endtask

    task automatic t_pack;
        setup(2'd0, 1'b0, 8'd127, 8'd0, 8'd0);
        push(32'h3F800000);
        expect_idle("R10 after 1");
        push(32'h40000000);
        push(32'h40400000);
        expect_idle("R8 after 3");
        push(32'hBF800000);
        expect_word("R8 lane order", 32'hFF030201);
        @(negedge clk);
        expect_idle("R8 one-cycle pulse");
    endtask

    task automatic t_flush;
        setup(2'd0, 1'b0, 8'd127, 8'd0, 8'd0);
        push(32'h3F800000);
        push(32'h40000000);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        expect_word("R9 partial flush", 32'h00000201);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        expect_idle("R9 empty flush");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nearest();
        t_trunc();
        t_special();
        t_sym();
        t_two();
        t_relu();
        t_pack();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=below %0d cycles", WATCHDOG, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule